// File: doc/BRIEF.md
# GPIO Interrupt Detect and Prioritizer

This block turns the levels of 32 already-synchronized GPIO pins into a single interrupt request for the CPU. Each pin has its own trigger setup. It can be level-sensitive with a chosen active polarity, or edge-sensitive on the falling edge, the rising edge or both. In edge mode a detected event can either be held until software clears it or be passed straight through for one cycle.

Software sets the block up through 16-bit register pairs on a simple write/read bus. Each pair has a low register for pins 0 to 15 and a high register for pins 16 to 31. Software reads the status bits back through the same bus and clears them by writing ones.

A status bit that is also enabled is pending. The OR of all pending bits is registered onto the request output. In the same cycle the block gives a valid flag and the 5-bit index of the pin that software should service first. Any pending pin in the low half is chosen ahead of every pin in the high half.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration, enable and status register reads 0, and `irq_o`, `irq_valid` and `irq_idx` are 0.
- R2: A pin in level mode (trigger-type bit 0) shows its status bit as 1 exactly in the cycles after it was sampled at its active level. Polarity bit 0 means active-low and polarity bit 1 means active-high.
- R3: For a level-mode pin that stays at its active level, writing 1 to its status bit does not clear it. The status bit reads 1 again on the next cycle.
- R4: An edge-mode pin with its hold bit at 1 keeps a detected event in status until a 1 is written to that status bit. Status bits written with 0 are unchanged.
- R5: An edge-mode pin with its hold bit at 0 shows its status bit as 1 only in the single cycle after the detected edge.
- R6: In edge mode the falling-enable bit alone detects falling edges, the rising-enable bit alone detects rising edges, and both bits together detect both edges.
- R7: The hold bit of a pin in level mode always reads 0, even right after a 1 has been written to it.
- R8: A pin is pending when its status bit and its enable bit are both 1. `irq_o` is the OR of all pending bits, delayed by one register stage.
- R9: With `irq_valid` high, `irq_idx` is the lowest pending pin in 0 to 15 if any pin there is pending. Otherwise it is 16 plus the lowest pending pin offset within 16 to 31.
- R10: When no pin is pending, `irq_valid` is 0 and `irq_idx` is 0, which marks the request as spurious.
- R11: Register map, low/high pairs: status 0x08/0x0A, enable 0x0C/0x0E, trigger type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling-enable 0x20/0x22, rising-enable 0x24/0x26. In each register, bit n of the low register is pin n and bit n of the high register is pin 16+n. Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| irq_valid | output | 1 | A pending pin exists |
| irq_idx | output | 5 | Index of the pin to service |

## Verification
The bench targets the following failure modes:
- Clearing status in level mode. If level-mode status could be cleared while the level stays active, the status bit would read 0 after the clear-write instead of 1.
- Shortened hold. If held edge events did not survive a pin returning to idle, the held bit would vanish early.
- Lingering pass-through pulse. If a pass-through event lingered, the status bit would stay high for two cycles.
- Swapped edge selects. If the falling and rising selects were swapped, the wrong edge would set status.
- Priority. Pins 3 and 20 are made pending together, so a design that scanned the high half first, or reported the highest pin, would return the wrong index.
- Spurious case. Clearing all enables checks that a stale index would not be left behind.
- Random mix. A long random run of pin toggles and register writes is compared cycle by cycle against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int HALF  = 16;
    localparam int PINS  = 2 * HALF;
    localparam int IDX_W = $clog2(PINS);
    localparam int AW    = 8;

    localparam logic [AW-1:0] OFS_STAT = 8'h08;
    localparam logic [AW-1:0] OFS_EN   = 8'h0C;
    localparam logic [AW-1:0] OFS_TYPE = 8'h10;
    localparam logic [AW-1:0] OFS_POL  = 8'h14;
    localparam logic [AW-1:0] OFS_HOLD = 8'h18;
    localparam logic [AW-1:0] OFS_FALL = 8'h20;
    localparam logic [AW-1:0] OFS_RISE = 8'h24;

    typedef logic [PINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t edge_mode;
        pinvec_t act_high;
        pinvec_t hold;
        pinvec_t fall_en;
        pinvec_t rise_en;
        pinvec_t irq_en;
    } cfg_t;

    typedef enum logic [2:0] {
        RG_NONE, RG_STAT, RG_EN, RG_TYPE, RG_POL, RG_HOLD, RG_FALL, RG_RISE
    } reg_id_t;

    typedef struct packed {
        reg_id_t id;
        logic    hi;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t r;
        r.id = RG_NONE;
        r.hi = 1'b0;
        if (a == OFS_STAT || a == OFS_STAT + 8'd2) r.id = RG_STAT;
        if (a == OFS_EN   || a == OFS_EN   + 8'd2) r.id = RG_EN;
        if (a == OFS_TYPE || a == OFS_TYPE + 8'd2) r.id = RG_TYPE;
        if (a == OFS_POL  || a == OFS_POL  + 8'd2) r.id = RG_POL;
        if (a == OFS_HOLD || a == OFS_HOLD + 8'd2) r.id = RG_HOLD;
        if (a == OFS_FALL || a == OFS_FALL + 8'd2) r.id = RG_FALL;
        if (a == OFS_RISE || a == OFS_RISE + 8'd2) r.id = RG_RISE;
        if (r.id != RG_NONE) r.hi = a[1];
        return r;
    endfunction

    function automatic pinvec_t put_half(input pinvec_t v, input logic hi,
                                         input logic [HALF-1:0] d);
        pinvec_t r;
        r = v;
        if (hi) r[PINS-1:HALF] = d;
        else    r[HALF-1:0]    = d;
        return r;
    endfunction

    function automatic logic [HALF-1:0] get_half(input pinvec_t v, input logic hi);
        return hi ? v[PINS-1:HALF] : v[HALF-1:0];
    endfunction

    function automatic logic [IDX_W-2:0] lowest_set(input logic [HALF-1:0] v);
        logic [IDX_W-2:0] r;
        r = '0;
        for (int i = HALF - 1; i >= 0; i--) begin
            if (v[i]) r = i[IDX_W-2:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  dec_t                 dec,
    input  logic [HALF-1:0]      wdata,
    output cfg_t                 cfg
);
    cfg_t cfg_n;

    always_comb begin
        cfg_n = cfg;
        if (wr) begin
            unique case (dec.id)
                RG_EN:   cfg_n.irq_en    = put_half(cfg.irq_en,    dec.hi, wdata);
                RG_TYPE: cfg_n.edge_mode = put_half(cfg.edge_mode, dec.hi, wdata);
                RG_POL:  cfg_n.act_high  = put_half(cfg.act_high,  dec.hi, wdata);
                RG_HOLD: cfg_n.hold      = put_half(cfg.hold,      dec.hi, wdata);
                RG_FALL: cfg_n.fall_en   = put_half(cfg.fall_en,   dec.hi, wdata);
                RG_RISE: cfg_n.rise_en   = put_half(cfg.rise_en,   dec.hi, wdata);
                default: ;
            endcase
        end
        // a pin in level mode never keeps a hold setting
        cfg_n.hold = cfg_n.hold & cfg_n.edge_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else     cfg <= cfg_n;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t pin,
    input  pinvec_t edge_mode,
    input  pinvec_t act_high,
    input  pinvec_t hold,
    input  pinvec_t fall_en,
    input  pinvec_t rise_en,
    input  pinvec_t clr,
    output pinvec_t stat
);
    pinvec_t prev;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic hit;
        always_comb begin
            if (edge_mode[p])
                hit = (fall_en[p] & prev[p] & ~pin[p]) |
                      (rise_en[p] & ~prev[p] & pin[p]);
            else
                hit = act_high[p] ? pin[p] : ~pin[p];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev[p] <= 1'b0;
                stat[p] <= 1'b0;
            end else begin
                prev[p] <= pin[p];
                if (edge_mode[p] && hold[p])
                    stat[p] <= (stat[p] & ~clr[p]) | hit;
                else
                    stat[p] <= hit;
            end
        end
    end
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pinvec_t          pend,
    output logic             irq_o,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_idx
);
    logic [1:0]           any_h;
    logic [IDX_W-2:0]     low_i [2];
    logic [IDX_W-1:0]     idx_n;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign any_h[h] = |pend[h*HALF +: HALF];
        assign low_i[h] = lowest_set(pend[h*HALF +: HALF]);
    end

    always_comb begin
        if (any_h[0])      idx_n = {1'b0, low_i[0]};
        else if (any_h[1]) idx_n = {1'b1, low_i[1]};
        else               idx_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o     <= 1'b0;
            irq_valid <= 1'b0;
            irq_idx   <= '0;
        end else begin
            irq_o     <= |any_h;
            irq_valid <= |any_h;
            irq_idx   <= idx_n;
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PINS-1:0]  pin_lvl,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [HALF-1:0]  reg_wdata,
    output logic [HALF-1:0]  reg_rdata,
    output logic             irq_o,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_idx
);
    dec_t    dec;
    cfg_t    cfg;
    pinvec_t stat;
    pinvec_t clr;
    pinvec_t pend;

    assign dec  = decode(reg_addr);
    assign clr  = (reg_wr && dec.id == RG_STAT) ? put_half('0, dec.hi, reg_wdata) : '0;
    assign pend = stat & cfg.irq_en;

    gpio_irq_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .dec(dec), .wdata(reg_wdata), .cfg(cfg)
    );

    gpio_irq_detect u_det (
        .clk(clk), .rst(rst), .pin(pin_lvl),
        .edge_mode(cfg.edge_mode), .act_high(cfg.act_high), .hold(cfg.hold),
        .fall_en(cfg.fall_en), .rise_en(cfg.rise_en), .clr(clr), .stat(stat)
    );

    gpio_irq_prio u_prio (
        .clk(clk), .rst(rst), .pend(pend),
        .irq_o(irq_o), .irq_valid(irq_valid), .irq_idx(irq_idx)
    );

    always_comb begin
        unique case (dec.id)
            RG_STAT: reg_rdata = get_half(stat,          dec.hi);
            RG_EN:   reg_rdata = get_half(cfg.irq_en,    dec.hi);
            RG_TYPE: reg_rdata = get_half(cfg.edge_mode, dec.hi);
            RG_POL:  reg_rdata = get_half(cfg.act_high,  dec.hi);
            RG_HOLD: reg_rdata = get_half(cfg.hold,      dec.hi);
            RG_FALL: reg_rdata = get_half(cfg.fall_en,   dec.hi);
            RG_RISE: reg_rdata = get_half(cfg.rise_en,   dec.hi);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input pinvec_t          pend,
    input cfg_t             cfg,
    input logic             irq_o,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_idx
);
    assert_irq_latency_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|pend));

    assert_idx_is_pending_R9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((($past(pend) >> irq_idx) & 32'd1) != 32'd0));

    assert_idx_is_lowest_R9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (($past(pend) & ((32'd1 << irq_idx) - 32'd1)) == 32'd0));

    assert_spurious_idx_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_idx == '0 && !irq_o));

    assert_level_no_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.hold & ~cfg.edge_mode) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .pend(pend), .cfg(cfg),
    .irq_o(irq_o), .irq_valid(irq_valid), .irq_idx(irq_idx)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_lvl = 32'hFFFF_FFFF;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_o, irq_valid;
    logic [4:0]  irq_idx;

    always #10 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_valid(irq_valid), .irq_idx(irq_idx)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] pins = 32'hFFFF_FFFF;
    logic [31:0] m_type = 0, m_pol = 0, m_hold = 0, m_fall = 0, m_rise = 0;
    logic [31:0] m_en = 0, m_stat = 0, m_prev = 0;
    logic        m_irq = 0, m_valid = 0;
    logic [4:0]  m_idx = 0;
    logic [15:0] last_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] v, input bit hi,
                                          input logic [15:0] d);
        logic [31:0] r = v;
        if (hi) r[31:16] = d; else r[15:0] = d;
        return r;
    endfunction

    function automatic logic [15:0] mread(input logic [7:0] a);
        logic [31:0] v;
        case (a & 8'hFD)
            8'h08: v = m_stat;
            8'h0C: v = m_en;
            8'h10: v = m_type;
            8'h14: v = m_pol;
            8'h18: v = m_hold;
            8'h20: v = m_fall;
            8'h24: v = m_rise;
            default: return 16'h0;
        endcase
        return a[1] ? v[31:16] : v[15:0];
    endfunction

    // lowest pending pin of the low half first, then of the high half
    function automatic logic [4:0] pick(input logic [31:0] p);
        for (int i = 0; i < 16; i++) if (p[i]) return i[4:0];
        for (int i = 16; i < 32; i++) if (p[i]) return i[4:0];
        return 5'd0;
    endfunction

    task automatic model_step(input bit wr, input logic [7:0] a, input logic [15:0] d);
        logic [31:0] pend = m_stat & m_en;
        logic [31:0] clr = 0;
        logic [31:0] nstat;
        logic [7:0]  b = a & 8'hFD;
        bit hi = a[1];
        m_irq = |pend;
        m_valid = |pend;
        m_idx = pick(pend);
        if (wr && b == 8'h08) clr = merge(32'h0, hi, d);
        for (int p = 0; p < 32; p++) begin
            bit hit;
            if (m_type[p])
                hit = (m_fall[p] && m_prev[p] && !pins[p]) ||
                      (m_rise[p] && !m_prev[p] && pins[p]);
            else
                hit = m_pol[p] ? pins[p] : !pins[p];
            if (m_type[p] && m_hold[p]) nstat[p] = (m_stat[p] && !clr[p]) || hit;
            else                        nstat[p] = hit;
        end
        m_stat = nstat;
        m_prev = pins;
        if (wr) begin
            case (b)
                8'h0C: m_en   = merge(m_en, hi, d);
                8'h10: m_type = merge(m_type, hi, d);
                8'h14: m_pol  = merge(m_pol, hi, d);
                8'h18: m_hold = merge(m_hold, hi, d);
                8'h20: m_fall = merge(m_fall, hi, d);
                8'h24: m_rise = merge(m_rise, hi, d);
                default: ;
            endcase
        end
        m_hold = m_hold & m_type;
    endtask

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; pin_lvl = pins;
        #1;
        last_rd = reg_rdata;
        if (!wr) chk(reg_rdata == mread(a), "R11 read", {16'h0, reg_rdata}, {16'h0, mread(a)});
        @(posedge clk);
        model_step(wr, a, d);
        #1;
        chk(irq_o == m_irq, "R8 irq", {31'h0, irq_o}, {31'h0, m_irq});
        chk(irq_valid == m_valid && irq_idx == m_idx,
            m_valid ? "R9 idx" : "R10 spurious",
            {26'h0, irq_valid, irq_idx}, {26'h0, m_valid, m_idx});
    endtask

    task automatic wrr(input logic [7:0] a, input logic [15:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic rdx(input logic [7:0] a, input logic [15:0] exp, input string tag);
        cyc(1'b0, a, 16'h0);
        chk(last_rd == exp, tag, {16'h0, last_rd}, {16'h0, exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 16'h0);
    endtask

    localparam logic [7:0] ADDRS [14] = '{8'h08, 8'h0A, 8'h0C, 8'h0E, 8'h10, 8'h12,
                                         8'h14, 8'h16, 8'h18, 8'h1A, 8'h20, 8'h22,
                                         8'h24, 8'h26};

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!irq_o && !irq_valid && irq_idx == 0, "R1 outputs",
            {26'h0, irq_o, irq_idx}, 32'h0);
        for (int i = 0; i < 14; i++) rdx(ADDRS[i], 16'h0, "R1 regs");

        // R2 level, active-low default
        pins[3] = 1'b0;
        idle(1);
        rdx(8'h08, 16'h0008, "R2 active-low level");
        // R3 clear has no lasting effect while level persists
        wrr(8'h08, 16'h0008);
        rdx(8'h08, 16'h0008, "R3 level w1c");
        // R2 active-high
        wrr(8'h14, 16'h0008);
        idle(1);
        rdx(8'h08, 16'h0000, "R2 active-high inactive");
        wrr(8'h14, 16'h0000);
        // R8 enable
        wrr(8'h0C, 16'h0008);
        idle(1);
        chk(irq_o == 1'b1, "R8 irq raised", {31'h0, irq_o}, 32'h1);
        chk(irq_idx == 5'd3, "R9 idx 3", {27'h0, irq_idx}, 32'd3);
        // R9 low half beats high half
        pins[20] = 1'b0;
        wrr(8'h0E, 16'h0010);
        idle(2);
        chk(irq_valid && irq_idx == 5'd3, "R9 low first", {27'h0, irq_idx}, 32'd3);
        pins[3] = 1'b1;
        idle(2);
        chk(irq_valid && irq_idx == 5'd20, "R9 high half", {27'h0, irq_idx}, 32'd20);
        // R10 spurious
        wrr(8'h0E, 16'h0000);
        idle(2);
        chk(!irq_valid && irq_idx == 0 && !irq_o, "R10 none pending",
            {26'h0, irq_valid, irq_idx}, 32'h0);
        pins[20] = 1'b1;
        wrr(8'h0C, 16'h0000);
        // R7 hold ignored in level mode
        wrr(8'h18, 16'hFFFF);
        rdx(8'h18, 16'h0000, "R7 hold in level mode");
        // R4 edge hold, falling
        wrr(8'h10, 16'h0020);
        wrr(8'h18, 16'h0020);
        wrr(8'h20, 16'h0020);
        idle(1);
        pins[5] = 1'b0;
        idle(1);
        rdx(8'h08, 16'h0020, "R6 falling detected");
        pins[5] = 1'b1;
        idle(2);
        rdx(8'h08, 16'h0020, "R4 held after idle");
        wrr(8'h08, 16'h0000);
        rdx(8'h08, 16'h0020, "R4 zero write keeps");
        wrr(8'h08, 16'h0020);
        rdx(8'h08, 16'h0000, "R4 w1c clears");
        // R6 rising only
        wrr(8'h20, 16'h0000);
        wrr(8'h24, 16'h0020);
        pins[5] = 1'b0;
        idle(1);
        rdx(8'h08, 16'h0000, "R6 rising ignores fall");
        pins[5] = 1'b1;
        idle(1);
        rdx(8'h08, 16'h0020, "R6 rising detected");
        wrr(8'h08, 16'h0020);
        // R6 both edges
        wrr(8'h20, 16'h0020);
        pins[5] = 1'b0;
        idle(1);
        rdx(8'h08, 16'h0020, "R6 both edges fall");
        wrr(8'h08, 16'h0020);
        // R5 pass-through
        wrr(8'h18, 16'h0000);
        pins[5] = 1'b1;
        idle(1);
        rdx(8'h08, 16'h0020, "R5 pulse first cycle");
        rdx(8'h08, 16'h0000, "R5 pulse gone");

        // random mix against the model
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 100;
            if ($urandom % 3 == 0) pins[$urandom % 32] ^= 1'b1;
            if (r < 35)
                cyc(1'b1, ADDRS[$urandom % 14], 16'($urandom));
            else if (r < 40)
                cyc(1'b1, 8'h30, 16'($urandom));
            else if (r < 45)
                cyc(1'b0, 8'h2A, 16'h0);
            else
                cyc(1'b0, ADDRS[$urandom % 14], 16'h0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule